// File: doc/BRIEF.md
# Trigger Activity Capture FIFO

This block is a 32-bit wide, 128-entry capture buffer for words that describe trigger activity. It works like the sample memory of a logic analyser. While the system waits for a trigger, the buffer keeps a rolling window of the most recent half-depth words. Once that window is filled, each new word displaces the oldest one.

A trigger pulse switches the buffer into post-trigger mode. In that mode incoming words are accepted until every entry is occupied. The buffer then freezes and ignores further words, so the history around the event is preserved for software to read out. A rearm pulse, issued when the system's busy flag is cleared, empties the buffer and returns it to pre-trigger mode.

Reading is a pop of the oldest entry. The popped word appears on a registered data output. A status word reports:

- the occupancy,
- empty and full,
- the trigger and freeze state.

Top module: `trig_log_fifo`

## Requirements
- R1: After reset the status word is zero except the empty flag (bit 8), and the read-data output is zero.
- R2: In pre-trigger mode, while fewer than 64 entries are held, each accepted write adds one entry, and entries are returned in write order.
- R3: In pre-trigger mode with 64 entries held, a write without a read discards the oldest entry, so occupancy stays at 64 and the most recent 64 words are kept.
- R4: A trigger pulse sets the triggered flag (bit 10) from the next cycle on. A write in the same cycle as the trigger still follows the pre-trigger rule. Further trigger pulses change nothing.
- R5: In post-trigger mode, writes are accepted without discarding until 128 entries are held. At that point the full flag (bit 9) and the frozen flag (bit 11) are set.
- R6: While frozen, writes are ignored even after reads have lowered the occupancy, until a rearm.
- R7: A rearm pulse empties the buffer, clears the triggered and frozen flags, and zeroes the read-data output. Rearm takes priority over a write, read or trigger in the same cycle.
- R8: A read of a non-empty buffer removes the oldest entry, and that word appears on the read-data output in the cycle after the read. Otherwise the output holds its value.
- R9: A read of an empty buffer drives zero on the read-data output and leaves the occupancy at zero.
- R10: A read and a write in the same cycle on a non-empty, non-frozen buffer leave the occupancy unchanged. At 64 entries in pre-trigger mode the read stands in for the discard.
- R11: The status word holds the occupancy in bits 7:0, empty in bit 8, full in bit 9, triggered in bit 10 and frozen in bit 11. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one activity word |
| wr_data | input | 32 | Activity word to log |
| trig | input | 1 | Trigger event pulse |
| rearm | input | 1 | Empty the buffer and return to pre-trigger mode |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 32 | Word popped by the previous read |
| status | output | 32 | Occupancy and mode flags |

## Verification
Each pattern the bench applies separates a different failure:

- **Pre-trigger depth sweep.** Burst lengths run from empty through well past half depth, each burst followed by a full drain. This separates a correct oldest-first discard from a buffer that stops accepting words, and from one that drops the newest word instead.
- **Trigger grid.** A grid of pre-fill levels and post-trigger lengths, with values computed arithmetically, shows whether the pre-trigger window survives the trigger. It also shows whether the buffer freezes at exactly full.
- **Frozen read-then-write.** A read followed by a write while frozen distinguishes a real freeze from a plain full check.
- **Same-cycle collisions.** Read and write together at half depth, a write together with a trigger, and rearm together with every other input each test one ordering rule.

// File: rtl/trig_log_pkg.sv
package trig_log_pkg;

    // Status word field positions (the occupancy occupies bits 7:0)
    localparam int ST_CNT_W  = 8;
    localparam int ST_EMPTY  = 8;
    localparam int ST_FULL   = 9;
    localparam int ST_TRIG   = 10;
    localparam int ST_FROZEN = 11;
    localparam int ST_W      = 32;

    typedef enum logic {
        MODE_PRE  = 1'b0,
        MODE_POST = 1'b1
    } log_mode_e;

endpackage

// File: rtl/trig_log_mem.sv
module trig_log_mem #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_fire,
    input  logic             rd_zero,
    input  logic             rd_clear,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdat_d, rdat_q;

    // Storage array: no reset, written only on an accepted write
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Read-data register: pop loads the oldest word, empty read or rearm loads zero
    always_comb begin
        rdat_d = rdat_q;
        if (rd_clear || rd_zero) begin
            rdat_d = '0;
        end else if (rd_fire) begin
            rdat_d = mem_q[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdat_q <= '0;
        end else begin
            rdat_q <= rdat_d;
        end
    end

    assign rd_data = rdat_q;

endmodule

// File: rtl/trig_log_ctrl.sv
module trig_log_ctrl
    import trig_log_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          trig,
    input  logic          rearm,
    input  logic          rd_en,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic          rd_fire,
    output logic          rd_zero,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count,
    output log_mode_e     mode,
    output logic          frozen
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        log_mode_e     mode;
        logic          frozen;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  wr_ok, rd_ok, drop, dec;

    always_comb begin
        st_d  = st_q;
        wr_ok = 1'b0;
        rd_ok = 1'b0;
        drop  = 1'b0;
        dec   = 1'b0;
        rd_zero = 1'b0;
        if (rearm) begin
            st_d = '0;
        end else begin
            rd_ok   = rd_en && (st_q.cnt != '0);
            rd_zero = rd_en && (st_q.cnt == '0);
            wr_ok   = wr_en && !st_q.frozen &&
                      ((st_q.cnt != CW'(DEPTH)) || rd_ok);
            // Pre-trigger window: make room by discarding the oldest entry
            drop    = wr_ok && (st_q.mode == MODE_PRE) &&
                      (st_q.cnt == CW'(HALF)) && !rd_ok;
            dec     = rd_ok || drop;
            st_d.wp  = st_q.wp + AW'(wr_ok);
            st_d.rp  = st_q.rp + AW'(dec);
            st_d.cnt = st_q.cnt + CW'(wr_ok) - CW'(dec);
            if ((st_q.mode == MODE_POST) && (st_d.cnt == CW'(DEPTH))) begin
                st_d.frozen = 1'b1;
            end
            if (trig) begin
                st_d.mode = MODE_POST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_fire = wr_ok;
    assign wr_addr = st_q.wp;
    assign rd_fire = rd_ok;
    assign rd_addr = st_q.rp;
    assign count   = st_q.cnt;
    assign mode    = st_q.mode;
    assign frozen  = st_q.frozen;

endmodule

// File: rtl/trig_log_fifo.sv
module trig_log_fifo
    import trig_log_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             trig,
    input  logic             rearm,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [ST_W-1:0]  status
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          wr_fire, rd_fire, rd_zero, frozen;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] count;
    log_mode_e     mode;

    trig_log_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .trig    (trig),
        .rearm   (rearm),
        .rd_en   (rd_en),
        .wr_fire (wr_fire),
        .wr_addr (wr_addr),
        .rd_fire (rd_fire),
        .rd_zero (rd_zero),
        .rd_addr (rd_addr),
        .count   (count),
        .mode    (mode),
        .frozen  (frozen)
    );

    trig_log_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_fire  (rd_fire),
        .rd_zero  (rd_zero),
        .rd_clear (rearm),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    always_comb begin
        status                  = '0;
        status[ST_CNT_W-1:0]    = ST_CNT_W'(count);
        status[ST_EMPTY]        = (count == '0);
        status[ST_FULL]         = (count == CW'(DEPTH));
        status[ST_TRIG]         = (mode == MODE_POST);
        status[ST_FROZEN]       = frozen;
    end

endmodule

// File: rtl/trig_log_fifo_chk.sv
module trig_log_fifo_chk #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             trig,
    input logic             rearm,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic [31:0]      status
);

    a_r3_window_cap: assert property (@(posedge clk) disable iff (!rst_n)
        !status[10] |-> (status[7:0] <= 8'(DEPTH / 2)));

    a_r4_trig_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !rearm) |=> status[10]);

    a_r5_full_at_depth: assert property (@(posedge clk) disable iff (!rst_n)
        status[9] |-> (status[7:0] == 8'(DEPTH) && status[11]));

    a_r6_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (status[11] && !rearm) |=> status[11]);

    a_r6_frozen_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (status[11] && wr_en && !rd_en && !rearm) |=> $stable(status[7:0]));

    a_r7_rearm_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (status[7:0] == 8'd0 && !status[10] && !status[11] && rd_data == '0));

    a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status[8] && rd_en && !rearm) |=> (rd_data == '0));

    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[31:12] == 20'd0);

endmodule

bind trig_log_fifo trig_log_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .trig    (trig),
    .rearm   (rearm),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .status  (status)
);

// File: tb/sim_trig_log_fifo.sv
`timescale 1ns/1ps
module sim_trig_log_fifo;

    localparam int DEPTH = 128;
    localparam int HALF  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        trig = 1'b0;
    logic        rearm = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state built from the requirements
    logic [31:0] mq[$];
    bit          m_trig = 1'b0;
    bit          m_frz  = 1'b0;
    logic [31:0] m_rd   = '0;

    always #4 clk = ~clk;

    trig_log_fifo u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .trig(trig), .rearm(rearm), .rd_en(rd_en),
        .rd_data(rd_data), .status(status)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[7:0] = 8'(mq.size());
        s[8]   = (mq.size() == 0);
        s[9]   = (mq.size() == DEPTH);
        s[10]  = m_trig;
        s[11]  = m_frz;
        return s;
    endfunction

    // One clock with the given inputs; model update; compare after the edge
    task automatic step(input bit w, input logic [31:0] d, input bit t,
                        input bit ra, input bit r, input string req);
        bit rok, wok;
        int sz;
        @(negedge clk);
        wr_en = w; wr_data = d; trig = t; rearm = ra; rd_en = r;
        @(posedge clk);
        if (ra) begin
            mq.delete(); m_trig = 0; m_frz = 0; m_rd = '0;
        end else begin
            sz  = mq.size();
            rok = r && (sz > 0);
            wok = w && !m_frz && (sz < DEPTH || rok);
            if (r) m_rd = rok ? mq[0] : 32'h0;
            if (rok) void'(mq.pop_front());
            if (wok) begin
                if (!m_trig && sz == HALF && !rok) void'(mq.pop_front());
                mq.push_back(d);
            end
            if (m_trig && mq.size() == DEPTH) m_frz = 1;
            if (t) m_trig = 1;
        end
        #1;
        chk(status == exp_status(), {req, " R11 status"}, status, exp_status());
        chk(rd_data == m_rd, {req, " R8 rd_data"}, rd_data, m_rd);
        wr_en = 0; trig = 0; rearm = 0; rd_en = 0;
    endtask

    task automatic drain(input string req);
        int n = mq.size();
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(status == 32'h0000_0100, "R1 status", status, 32'h0000_0100);
        chk(rd_data == 32'h0, "R1 rd_data", rd_data, 32'h0);

        // R2/R3: pre-trigger depth sweep with arithmetic checks
        for (int n = 0; n <= 140; n += 7) begin
            int m;
            step(0, 0, 0, 1, 0, "R7");
            for (int i = 0; i < n; i++) step(1, n * 1000 + i, 0, 0, 0, "R2");
            m = (n < HALF) ? n : HALF;
            chk(status[7:0] == 8'(m), "R3 count", {24'h0, status[7:0]}, 32'(m));
            for (int k = 0; k < m; k++) begin
                step(0, 0, 0, 0, 1, "R3");
                chk(rd_data == 32'(n * 1000 + (n - m) + k), "R3 oldest-first",
                    rd_data, 32'(n * 1000 + (n - m) + k));
            end
            step(0, 0, 0, 0, 1, "R9");
            chk(rd_data == 32'h0 && status[8], "R9 empty read", rd_data, 32'h0);
        end

        // R4/R5/R6: trigger grid
        for (int pi = 0; pi < 3; pi++) begin
            for (int ki = 0; ki < 5; ki++) begin
                int p, k, m, kk;
                p = (pi == 0) ? 0 : (pi == 1) ? 10 : 90;
                k = (ki == 0) ? 0 : (ki == 1) ? 30 : (ki == 2) ? 64 : (ki == 3) ? 127 : 150;
                step(0, 0, 0, 1, 0, "R7");
                for (int i = 0; i < p; i++) step(1, 32'hA0000 + i, 0, 0, 0, "R2");
                step(0, 0, 1, 0, 0, "R4");
                chk(status[10], "R4 triggered flag", status, 32'h400);
                for (int j = 0; j < k; j++) step(1, 32'hB0000 + j, 0, 0, 0, "R5");
                m  = (p < HALF) ? p : HALF;
                kk = (m + k > DEPTH) ? DEPTH - m : k;
                chk(status[7:0] == 8'(m + kk), "R5 count", {24'h0, status[7:0]}, 32'(m + kk));
                chk(status[11] == (m + kk == DEPTH), "R5 frozen", status, 32'(m + kk));
                step(0, 0, 1, 0, 0, "R4");
                if (status[11]) begin
                    step(0, 0, 0, 0, 1, "R6");
                    step(1, 32'hDEAD, 0, 0, 0, "R6");
                    chk(status[7:0] == 8'(DEPTH - 1), "R6 write ignored",
                        {24'h0, status[7:0]}, 32'(DEPTH - 1));
                end
                drain("R5");
            end
        end

        // R10: read with write at half depth, pre-trigger
        step(0, 0, 0, 1, 0, "R7");
        for (int i = 0; i < HALF; i++) step(1, 32'hC000 + i, 0, 0, 0, "R2");
        step(1, 32'hCFFF, 0, 0, 1, "R10");
        chk(status[7:0] == 8'(HALF) && rd_data == 32'hC000, "R10 read+write",
            rd_data, 32'hC000);
        // R4: write in the trigger cycle still discards
        step(1, 32'hE000, 1, 0, 0, "R4");
        chk(status[7:0] == 8'(HALF), "R4 write with trig", {24'h0, status[7:0]}, 32'(HALF));
        step(1, 32'hE001, 0, 0, 0, "R5");
        chk(status[7:0] == 8'(HALF + 1), "R5 post grows", {24'h0, status[7:0]}, 32'(HALF + 1));
        // R7: rearm beats everything else
        step(1, 32'hF000, 1, 1, 1, "R7");
        chk(status == 32'h100 && rd_data == 0, "R7 rearm priority", status, 32'h100);
        step(1, 32'hF001, 0, 0, 1, "R9");
        chk(status[7:0] == 8'd1 && rd_data == 0, "R9 empty read with write", rd_data, 0);
        drain("R8");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule